// File: doc/BRIEF.md
# Top-up Injection Gating Controller

This block frames a gating window around a top-up injection into a storage ring. A pre-injection announcement starts a sequence. After a programmable hold-off the gate opens for a programmable width, then closes. The block then waits for the post-injection notification. Two watchdog windows bound the sequence. If either window runs out before the expected event, the block reports a fault on the red indicator until the next announcement.

Each gate is driven three ways: active-high, active-low, and a machine-level copy. Four 32-bit timing values are reloaded from a write strobe. All times are counted in ticks of a single-cycle timebase enable. The green indicator is steady while the block is waiting for an injection and blinks while a sequence runs.

Top module: `topup_gate_ctrl`

## Requirements
- R1: After reset, `gate_pos` and `gate_mach` are 0, `gate_neg` is 1, `led_green` is 1 and `led_red` is 0. The timing values reset to hold-off 2000, width 500, pre window 120000 and post window 300000 ticks.
- R2: Both trigger inputs pass through two synchroniser flops and a rising-edge detector. A level held high yields one event. With `tick` high every cycle, if a pre trigger rises just before clock edge N, the gate rises at edge N+2+hold-off.
- R3: The gate opens after exactly hold-off ticks, counted from the edge on which the sequence starts.
- R4: The gate stays high for exactly width ticks and then closes. The block then waits for a post trigger, which returns it to idle with `led_red` at 0.
- R5: If no post trigger arrives within post-window ticks after the gate closes, the block enters the fault state and `led_red` goes to 1.
- R6: The pre window counts ticks from the start of the sequence through hold-off and gate. If it reaches the pre-window value before the gate closes, the gate drops at once and `led_red` goes to 1. This timeout takes priority over a normal phase end on the same tick.
- R7: In the fault state `led_red` stays at 1 until the next pre trigger, which starts a new sequence and clears it.
- R8: A post trigger outside the post-wait phase, and a pre trigger while a sequence is running, are ignored. They leave the gate timing and `led_red` unchanged.
- R9: A one-cycle `cfg_wr` latches all four timing values and clears the counters. If a sequence is active, the gate drops on the next edge and the block returns to idle. A write in the fault state leaves it in the fault state.
- R10: The counters advance only on cycles where `tick` is 1. With `tick` held at 0, a started sequence never opens its gate.
- R11: `gate_neg` is always the complement of `gate_pos`, and `gate_mach` always equals `gate_pos`.
- R12: `led_green` is 1 whenever no sequence is active. During a sequence it toggles every BLINK_TICKS ticks, starting high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one cycle per tick |
| pre_trig | input | 1 | Asynchronous pre-injection announcement |
| post_trig | input | 1 | Asynchronous post-injection notification |
| cfg_wr | input | 1 | Write strobe for the four timing values |
| cfg_holdoff | input | 32 | Hold-off in ticks |
| cfg_width | input | 32 | Gate width in ticks |
| cfg_pre_max | input | 32 | Pre-window limit in ticks |
| cfg_post_max | input | 32 | Post-window limit in ticks |
| gate_pos | output | 1 | Active-high gate |
| gate_neg | output | 1 | Active-low gate |
| gate_mach | output | 1 | Machine-level gate |
| led_green | output | 1 | Waiting (steady) or running (blinking) |
| led_red | output | 1 | Fault: a window ran out |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle nature of each trigger event;
- the gate being high only in the gate phase;
- counter stability without `tick`;
- the fault state holding until an announcement;
- the return to idle after a post event or a write;
- green being steady outside a sequence.

Other behaviour is shown only by the bench scenarios. These are the exact rise cycle and width of each gate against the programmed values, the truncation by the pre window, and the post timeout. They also cover triggers that are ignored and the abort by a mid-sequence write followed by a pulse with the new values.

// File: rtl/tg_pkg.sv
package tg_pkg;

    localparam int CNT_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_GATE,
        ST_WAITP,
        ST_FAULT
    } tg_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] holdoff;
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] pre_max;
        logic [CNT_W-1:0] post_max;
    } tg_cfg_t;

    // True on the tick that completes a window of lim ticks (zero acts as one).
    function automatic logic tg_expired(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] lim);
        logic [CNT_W:0] nxt;
        nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        return nxt >= {1'b0, lim};
    endfunction

    function automatic logic tg_running(input tg_state_e s);
        return (s == ST_HOLD) || (s == ST_GATE) || (s == ST_WAITP);
    endfunction

endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] evt
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], raw[i]};
        end
        assign evt[i] = sh[1] & ~sh[2];

        p_evt_single_r2: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> !evt[i]);
    end
endmodule

// File: rtl/tg_cfg.sv
module tg_cfg
    import tg_pkg::*;
#(
    parameter logic [CNT_W-1:0] HOLD_RST = 32'd2000,
    parameter logic [CNT_W-1:0] WID_RST  = 32'd500,
    parameter logic [CNT_W-1:0] PRE_RST  = 32'd120000,
    parameter logic [CNT_W-1:0] POST_RST = 32'd300000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] holdoff,
    input  logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] pre_max,
    input  logic [CNT_W-1:0] post_max,
    output tg_cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.holdoff  <= HOLD_RST;
            cfg.width    <= WID_RST;
            cfg.pre_max  <= PRE_RST;
            cfg.post_max <= POST_RST;
        end else if (wr) begin
            cfg.holdoff  <= holdoff;
            cfg.width    <= width;
            cfg.pre_max  <= pre_max;
            cfg.post_max <= post_max;
        end
    end

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg));
endmodule

// File: rtl/tg_seq.sv
module tg_seq
    import tg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      wr,
    input  logic      pre_evt,
    input  logic      post_evt,
    input  tg_cfg_t   cfg,
    output tg_state_e state_q,
    output logic      gate_q
);
    tg_state_e        state_n;
    logic [CNT_W-1:0] ph_cnt, win_cnt;
    logic             ph_clr, win_clr;

    always_comb begin
        state_n = state_q;
        ph_clr  = 1'b0;
        win_clr = 1'b0;
        if (wr) begin
            if (tg_running(state_q)) state_n = ST_IDLE;
            ph_clr  = 1'b1;
            win_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FAULT: begin
                    if (pre_evt) begin
                        state_n = ST_HOLD;
                        ph_clr  = 1'b1;
                        win_clr = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (tg_expired(win_cnt, cfg.pre_max)) begin
                            state_n = ST_FAULT;
                        end else if (tg_expired(ph_cnt, cfg.holdoff)) begin
                            state_n = ST_GATE;
                            ph_clr  = 1'b1;
                        end
                    end
                end
                ST_GATE: begin
                    if (tick) begin
                        if (tg_expired(win_cnt, cfg.pre_max)) begin
                            state_n = ST_FAULT;
                        end else if (tg_expired(ph_cnt, cfg.width)) begin
                            state_n = ST_WAITP;
                            ph_clr  = 1'b1;
                            win_clr = 1'b1;
                        end
                    end
                end
                ST_WAITP: begin
                    if (post_evt)
                        state_n = ST_IDLE;
                    else if (tick && tg_expired(win_cnt, cfg.post_max))
                        state_n = ST_FAULT;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            gate_q  <= 1'b0;
            ph_cnt  <= '0;
            win_cnt <= '0;
        end else begin
            state_q <= state_n;
            gate_q  <= (state_n == ST_GATE);
            if (ph_clr)                            ph_cnt <= '0;
            else if (tick && tg_running(state_q))  ph_cnt <= ph_cnt + 1'b1;
            if (win_clr)                           win_cnt <= '0;
            else if (tick && tg_running(state_q))  win_cnt <= win_cnt + 1'b1;
        end
    end

    p_gate_phase_r3: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> state_q == ST_GATE);
    p_post_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAITP && post_evt && !wr) |=> state_q == ST_IDLE);
    p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT && !pre_evt) |=> state_q == ST_FAULT);
    p_wr_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && tg_running(state_q)) |=> (state_q == ST_IDLE && !gate_q));
    p_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr && state_q == ST_HOLD) |=> $stable(ph_cnt));
endmodule

// File: rtl/tg_led.sv
module tg_led #(
    parameter int BLINK_TICKS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic running,
    output logic green
);
    localparam int BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [BW-1:0] B_LAST = BW'(BLINK_TICKS - 1);

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            green <= 1'b1;
            bcnt  <= '0;
        end else if (tick) begin
            if (bcnt == B_LAST) begin
                bcnt  <= '0;
                green <= ~green;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    p_green_steady_r12: assert property (@(posedge clk) disable iff (rst)
        !running |=> green);
endmodule

// File: rtl/topup_gate_ctrl.sv
module topup_gate_ctrl
    import tg_pkg::*;
#(
    parameter logic [CNT_W-1:0] HOLD_RST    = 32'd2000,
    parameter logic [CNT_W-1:0] WID_RST     = 32'd500,
    parameter logic [CNT_W-1:0] PRE_RST     = 32'd120000,
    parameter logic [CNT_W-1:0] POST_RST    = 32'd300000,
    parameter int               BLINK_TICKS = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pre_trig,
    input  logic             post_trig,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_holdoff,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_pre_max,
    input  logic [CNT_W-1:0] cfg_post_max,
    output logic             gate_pos,
    output logic             gate_neg,
    output logic             gate_mach,
    output logic             led_green,
    output logic             led_red
);
    logic [1:0] evt;
    tg_cfg_t    cfg;
    tg_state_e  state;
    logic       gate;

    tg_sync #(.N(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw ({post_trig, pre_trig}),
        .evt (evt)
    );

    tg_cfg #(
        .HOLD_RST (HOLD_RST),
        .WID_RST  (WID_RST),
        .PRE_RST  (PRE_RST),
        .POST_RST (POST_RST)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .holdoff  (cfg_holdoff),
        .width    (cfg_width),
        .pre_max  (cfg_pre_max),
        .post_max (cfg_post_max),
        .cfg      (cfg)
    );

    tg_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr       (cfg_wr),
        .pre_evt  (evt[0]),
        .post_evt (evt[1]),
        .cfg      (cfg),
        .state_q  (state),
        .gate_q   (gate)
    );

    tg_led #(.BLINK_TICKS(BLINK_TICKS)) u_led (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .running (tg_running(state)),
        .green   (led_green)
    );

    assign gate_pos  = gate;
    assign gate_neg  = ~gate;
    assign gate_mach = gate;
    assign led_red   = (state == ST_FAULT);

    p_red_gate_excl_r6: assert property (@(posedge clk) disable iff (rst)
        led_red |-> !gate_pos);
endmodule

// File: tb/topup_gate_ctrl_tb_top.sv
module topup_gate_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        pre_trig = 1'b0, post_trig = 1'b0, cfg_wr = 1'b0;
    logic [31:0] cfg_holdoff = '0, cfg_width = '0, cfg_pre_max = '0, cfg_post_max = '0;
    logic        gate_pos, gate_neg, gate_mach, led_green, led_red;

    always #(CLK_PERIOD/2) clk = ~clk;

    topup_gate_ctrl #(.BLINK_TICKS(3)) dut_i (
        .clk(clk), .rst(rst), .tick(tick),
        .pre_trig(pre_trig), .post_trig(post_trig), .cfg_wr(cfg_wr),
        .cfg_holdoff(cfg_holdoff), .cfg_width(cfg_width),
        .cfg_pre_max(cfg_pre_max), .cfg_post_max(cfg_post_max),
        .gate_pos(gate_pos), .gate_neg(gate_neg), .gate_mach(gate_mach),
        .led_green(led_green), .led_red(led_red)
    );

    typedef struct { int rise; int wid; string req; } exp_t;
    exp_t sbq[$];

    int  cyc = 0;
    int  n_chk = 0, n_fail = 0;
    int  rel_bad = 0;
    bit  green_low = 1'b0;
    bit  done = 1'b0;
    bit  prev_g = 1'b0;
    int  rise_c = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops one expected pulse per observed gate fall.
    always @(negedge clk) begin
        if (!rst) begin
            if (gate_neg !== ~gate_pos || gate_mach !== gate_pos) rel_bad++;
            if (!led_green) green_low = 1'b1;
            if (gate_pos && !prev_g) rise_c = cyc;
            if (!gate_pos && prev_g) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R8 unexpected gate pulse", rise_c, -1);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(rise_c == e.rise, {e.req, " gate rise cycle"}, rise_c, e.rise);
                    check(cyc - rise_c == e.wid, {e.req, " gate width"}, cyc - rise_c, e.wid);
                end
            end
            prev_g = gate_pos;
        end
    end

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Drives a pre trigger held 4 cycles; optionally pushes the expected pulse.
    task automatic fire_pre(input bit expect_pulse, input int dly, input int wid,
                            input string req, output int c);
        exp_t e;
        @(negedge clk);
        c = cyc;
        if (expect_pulse) begin
            e.rise = c + 3 + dly; e.wid = wid; e.req = req;
            sbq.push_back(e);
        end
        pre_trig = 1'b1;
        repeat (4) @(negedge clk);
        pre_trig = 1'b0;
    endtask

    task automatic fire_post();
        @(negedge clk);
        post_trig = 1'b1;
        repeat (4) @(negedge clk);
        post_trig = 1'b0;
    endtask

    task automatic write_cfg(input int h, input int w, input int pm, input int qm);
        @(negedge clk);
        cfg_holdoff = h; cfg_width = w; cfg_pre_max = pm; cfg_post_max = qm;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        int c, c2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(gate_pos == 1'b0, "R1 gate_pos reset", gate_pos, 0);
        check(gate_neg == 1'b1, "R1 gate_neg reset", gate_neg, 1);
        check(gate_mach == 1'b0, "R1 gate_mach reset", gate_mach, 0);
        check(led_green == 1'b1, "R1 green reset", led_green, 1);
        check(led_red == 1'b0, "R1 red reset", led_red, 0);
        rst = 1'b0;

        // R1 R2 R3 default values: hold-off 2000, width 500
        fire_pre(1'b1, 2000, 500, "R1 R3", c);
        wait_until(c + 2510);
        check(green_low == 1'b1, "R12 green blinks in sequence", green_low, 1);
        fire_post();
        repeat (6) @(negedge clk);
        check(led_red == 1'b0, "R4 red after post", led_red, 0);
        check(led_green == 1'b1, "R12 green steady idle", led_green, 1);

        // R8 post trigger in idle ignored
        write_cfg(5, 4, 20, 10);
        fire_post();
        repeat (6) @(negedge clk);
        check(gate_pos == 1'b0, "R8 post in idle gate", gate_pos, 0);
        check(led_red == 1'b0, "R8 post in idle red", led_red, 0);

        // R2 R4 small pulse; second pre during sequence ignored (R8); then R5 post timeout
        fire_pre(1'b1, 5, 4, "R2 R4 R8", c);
        fire_pre(1'b0, 0, 0, "R8", c2);
        wait_until(c + 20);
        check(led_red == 1'b0, "R5 red before post timeout", led_red, 0);
        wait_until(c + 25);
        check(led_red == 1'b1, "R5 red after post timeout", led_red, 1);

        // R7 red persists, cleared by next pre
        repeat (20) @(negedge clk);
        check(led_red == 1'b1, "R7 red persists", led_red, 1);
        fire_pre(1'b1, 5, 4, "R7", c);
        check(led_red == 1'b0, "R7 red cleared by pre", led_red, 0);
        wait_until(c + 14);
        fire_post();
        wait_until(c + 26);
        check(led_red == 1'b0, "R4 post return no red", led_red, 0);

        // R6 pre window truncates gate
        write_cfg(5, 4, 7, 10);
        fire_pre(1'b1, 5, 2, "R6", c);
        wait_until(c + 14);
        check(led_red == 1'b1, "R6 red after pre timeout", led_red, 1);

        // R10 no tick: gate never opens
        write_cfg(5, 4, 20, 10);
        @(negedge clk);
        tick = 1'b0;
        fire_pre(1'b0, 0, 0, "R10", c);
        wait_until(c + 40);
        check(gate_pos == 1'b0, "R10 gate held without tick", gate_pos, 0);
        begin
            exp_t e;
            e.rise = cyc + 5; e.wid = 4; e.req = "R10";
            sbq.push_back(e);
        end
        tick = 1'b1;
        wait_until(c + 55);
        fire_post();
        repeat (6) @(negedge clk);

        // R9 write during gate aborts; new values apply
        fire_pre(1'b1, 5, 2, "R9 abort", c);
        wait_until(c + 9);
        cfg_holdoff = 3; cfg_width = 6; cfg_pre_max = 20; cfg_post_max = 10;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        check(gate_pos == 1'b0, "R9 gate dropped", gate_pos, 0);
        check(led_red == 1'b0, "R9 no fault on abort", led_red, 0);
        check(led_green == 1'b1, "R9 idle after abort", led_green, 1);
        fire_pre(1'b1, 3, 6, "R9 new values", c);
        wait_until(c + 16);
        fire_post();
        repeat (6) @(negedge clk);

        check(sbq.size() == 0, "R3 all expected pulses seen", sbq.size(), 0);
        check(rel_bad == 0, "R11 output relation", rel_bad, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule